// File: doc/BRIEF.md
# Parallel Multi-Lane LED Waveform Encoder

This block drives up to `LANES` serial LED strips of the single-wire, pulse-width-coded kind, all at once and in lockstep. Pixels are written into an internal store as red/green/blue words. On each write they are permuted into the strip's wire order, so the store already holds the bytes in the order they are sent. A start pulse launches one frame. Every enabled lane then sends its own run of pixels: LED 0 first, three bytes per LED, most significant bit first.

All lanes share one slot timer with three events. At the slot start every enabled lane goes high. At the short mark, the lanes whose current bit is zero drop low. At the long mark, every lane is low. The next byte is fetched into a holding register while the current byte is being sent, so slots follow each other with no gap.

After a start, `busy` stays high for a fixed latch window measured from that start, and a further start is accepted only when the window has closed. All timing counts are worked out from `CLK_HZ` by integer division.

Top module: `led_lane_tx`

## Requirements
- R1: After reset, `busy` is 0 and every bit of `laneOut` is 0.
- R2: In normal mode, one bit slot lasts SLOT = CLK_HZ/800000 cycles. A 0 bit is high for SHORT = CLK_HZ*3/10000000 cycles and a 1 bit for LONG = CLK_HZ*3/4000000 cycles.
- R3: With `slowMode` at 1 when the start is accepted, the slot length and both high times are doubled for the whole frame.
- R4: Within a frame, all enabled lanes rise together at each slot start, and no lane rises at any other moment. Successive slots follow back to back, so the rise-to-rise spacing is exactly one slot.
- R5: Lane l sends the pixels stored for lane l, starting at LED 0. Each LED is sent as three bytes, each byte most significant bit first.
- R6: `wrColor` carries red in [23:16], green in [15:8] and blue in [7:0]. `colorOrder` picks the order of the sent bytes: 0 R,G,B; 1 R,B,G; 2 G,R,B; 3 G,B,R; 4 B,R,G; 5 B,G,R; 6 and 7 act as 0. The order is applied when the pixel is written.
- R7: Each enabled lane sends exactly `stripLen`*24 bits, with `stripLen` latched when the start is accepted. A length of 0 sends no bits.
- R8: `laneEn` is latched at start. A lane whose bit is 0 stays low for the whole frame.
- R9: A start seen while `busy` is 0 raises `busy` on the next cycle. `busy` then stays high for exactly BASE + BYTE*3*stripLen*(slow ? 2 : 1) cycles, where BASE is 300 us and BYTE is 10 us of clock cycles.
- R10: A start seen while `busy` is 1 is ignored. The frame under way and its busy window are unchanged, and no new frame follows.
- R11: While `busy` is 0, every bit of `laneOut` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Pixel write strobe |
| wrLane | input | LANEW | Lane of the pixel written |
| wrLed | input | LEDW | LED index within the lane |
| wrColor | input | 24 | Pixel colour, R/G/B from high to low |
| colorOrder | input | 3 | Wire byte order applied on write |
| stripLen | input | LENW | LEDs per lane for the next frame |
| laneEn | input | LANES | Lane enable mask for the next frame |
| slowMode | input | 1 | Half-rate timing for the next frame |
| start | input | 1 | Frame start pulse |
| busy | output | 1 | Frame or latch window in progress |
| laneOut | output | LANES | Serial waveform per lane |

## Verification
`busy` rises one cycle after the edge that accepts a start. A lane edge appears one cycle after the shared counter reaches a slot start, short mark or long mark. The bench samples on the falling clock edge and measures every high pulse and every rise-to-rise spacing as a whole number of cycles. This makes the width and period checks exact against SHORT, LONG and SLOT, independent of the fixed one-cycle latency. The busy window is counted cycle by cycle from the first sampled high to the first sampled low and compared with the closed-form length. Every decoded bit is compared with a bit stream the bench builds from its own pixel values and byte-order table.

// File: rtl/led_tx_pkg.sv
package led_tx_pkg;

  typedef enum logic [1:0] {
    TX_IDLE,
    TX_PREP,
    TX_SEND,
    TX_GAP
  } txState_e;

  // strobes from the sequencer to the lane datapath
  typedef struct packed {
    logic fetch;      // capture the addressed byte into the holding register
    logic slotStart;  // first cycle of a bit slot
    logic loadByte;   // slot start that begins a new byte
    logic markShort;  // zero-bit lanes fall
    logic markLong;   // every lane falls
  } txStrobe_t;

  localparam logic [2:0] ORD_RGB = 3'd0;
  localparam logic [2:0] ORD_RBG = 3'd1;
  localparam logic [2:0] ORD_GRB = 3'd2;
  localparam logic [2:0] ORD_GBR = 3'd3;
  localparam logic [2:0] ORD_BRG = 3'd4;
  localparam logic [2:0] ORD_BGR = 3'd5;

endpackage

// File: rtl/led_order_remap.sv
module led_order_remap
  import led_tx_pkg::*;
(
  input  logic [23:0] rgbIn,
  input  logic [2:0]  order,
  output logic [23:0] wireWord
);

  logic [7:0] red, green, blue;

  assign red   = rgbIn[23:16];
  assign green = rgbIn[15:8];
  assign blue  = rgbIn[7:0];

  // wireWord[23:16] is sent first
  always_comb begin
    case (order)
      ORD_RBG: wireWord = {red, blue, green};
      ORD_GRB: wireWord = {green, red, blue};
      ORD_GBR: wireWord = {green, blue, red};
      ORD_BRG: wireWord = {blue, red, green};
      ORD_BGR: wireWord = {blue, green, red};
      default: wireWord = {red, green, blue};
    endcase
  end

endmodule

// File: rtl/led_tx_ctrl.sv
module led_tx_ctrl
  import led_tx_pkg::*;
#(
  parameter int LANES     = 8,
  parameter int MAX_LEDS  = 8,
  parameter int LENW      = 4,
  parameter int SLOT_CYC  = 250,
  parameter int SHORT_CYC = 60,
  parameter int LONG_CYC  = 150,
  parameter int GAP_BASE  = 60000,
  parameter int GAP_BYTE  = 2000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [LENW-1:0]  stripLen,
  input  logic             slowMode,
  input  logic [LANES-1:0] laneEn,
  output txStrobe_t        stb,
  output logic [LENW-1:0]  rdLed,
  output logic [1:0]       rdSel,
  output logic [LANES-1:0] laneMaskQ,
  output logic             busy
);

  localparam int SW      = $clog2(2 * SLOT_CYC + 1);
  localparam int BW      = $clog2(3 * MAX_LEDS + 1);
  localparam int GAP_MAX = GAP_BASE + GAP_BYTE * 6 * MAX_LEDS;
  localparam int CW      = $clog2(GAP_MAX + 1);

  txState_e         state;
  logic [SW-1:0]    slotCnt;
  logic [2:0]       bitCnt;
  logic [BW-1:0]    bytesLeft;
  logic [CW-1:0]    gapCnt;
  logic [CW-1:0]    gapLimit;
  logic             slowQ;
  logic [LENW-1:0]  lenClamp;
  logic [CW-1:0]    gapCalc;
  logic [SW-1:0]    slotLen, shortAt, longAt;

  assign lenClamp = (int'(stripLen) > MAX_LEDS) ? LENW'(MAX_LEDS) : stripLen;
  assign gapCalc  = CW'(GAP_BASE) + CW'(GAP_BYTE) * CW'(lenClamp) * (slowMode ? CW'(6) : CW'(3));

  assign slotLen = slowQ ? SW'(2 * SLOT_CYC)  : SW'(SLOT_CYC);
  assign shortAt = slowQ ? SW'(2 * SHORT_CYC) : SW'(SHORT_CYC);
  assign longAt  = slowQ ? SW'(2 * LONG_CYC)  : SW'(LONG_CYC);

  assign busy = (state != TX_IDLE);

  always_comb begin
    stb           = '0;
    stb.slotStart = (state == TX_SEND) && (slotCnt == '0);
    stb.loadByte  = stb.slotStart && (bitCnt == 3'd0);
    stb.fetch     = (state == TX_PREP) || stb.loadByte;
    stb.markShort = (state == TX_SEND) && (slotCnt == shortAt);
    stb.markLong  = (state == TX_SEND) && (slotCnt == longAt);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= TX_IDLE;
      slotCnt   <= '0;
      bitCnt    <= '0;
      bytesLeft <= '0;
      gapCnt    <= '0;
      gapLimit  <= '0;
      slowQ     <= 1'b0;
      laneMaskQ <= '0;
      rdLed     <= '0;
      rdSel     <= '0;
    end else begin
      if (stb.fetch) begin
        if (rdSel == 2'd2) begin
          rdSel <= '0;
          rdLed <= rdLed + 1'b1;
        end else begin
          rdSel <= rdSel + 1'b1;
        end
      end
      if (state != TX_IDLE) gapCnt <= gapCnt + 1'b1;

      case (state)
        TX_IDLE: begin
          if (start) begin
            state     <= TX_PREP;
            gapCnt    <= '0;
            gapLimit  <= gapCalc;
            bytesLeft <= BW'(lenClamp) * BW'(3);
            slowQ     <= slowMode;
            laneMaskQ <= laneEn;
            rdLed     <= '0;
            rdSel     <= '0;
            slotCnt   <= '0;
            bitCnt    <= '0;
          end
        end
        TX_PREP: begin
          state <= (bytesLeft == '0) ? TX_GAP : TX_SEND;
        end
        TX_SEND: begin
          if (stb.loadByte) bytesLeft <= bytesLeft - 1'b1;
          if (slotCnt == slotLen - 1'b1) begin
            slotCnt <= '0;
            bitCnt  <= bitCnt + 1'b1;
            if (bitCnt == 3'd7 && bytesLeft == '0) state <= TX_GAP;
          end else begin
            slotCnt <= slotCnt + 1'b1;
          end
        end
        default: begin
          if (gapCnt >= gapLimit - 1'b1) state <= TX_IDLE;
        end
      endcase
    end
  end

endmodule

// File: rtl/led_tx_datapath.sv
module led_tx_datapath
  import led_tx_pkg::*;
#(
  parameter int LANES    = 8,
  parameter int MAX_LEDS = 8,
  parameter int LENW     = 4,
  parameter int LANEW    = 3,
  parameter int LEDW     = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [LANEW-1:0] wrLane,
  input  logic [LEDW-1:0]  wrLed,
  input  logic [23:0]      wrColor,
  input  logic [2:0]       colorOrder,
  input  txStrobe_t        stb,
  input  logic [LENW-1:0]  rdLed,
  input  logic [1:0]       rdSel,
  input  logic [LANES-1:0] laneMask,
  output logic [LANES-1:0] laneOut
);

  logic [23:0]      pix [LANES][MAX_LEDS];
  logic [23:0]      mapped;
  logic [LEDW-1:0]  rdLedSafe;
  logic [LANES-1:0] curBits;
  logic [LANES-1:0] laneQ;

  led_order_remap u_remap (
    .rgbIn    (wrColor),
    .order    (colorOrder),
    .wireWord (mapped)
  );

  always_ff @(posedge clk) begin
    if (wrEn && int'(wrLed) < MAX_LEDS && int'(wrLane) < LANES)
      pix[wrLane][wrLed] <= mapped;
  end

  assign rdLedSafe = (int'(rdLed) < MAX_LEDS) ? rdLed[LEDW-1:0] : '0;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [23:0] word;
    logic [7:0]  pick;
    logic [7:0]  holdQ;
    logic [7:0]  shiftQ;

    assign word = pix[l][rdLedSafe];

    always_comb begin
      case (rdSel)
        2'd0:    pick = word[23:16];
        2'd1:    pick = word[15:8];
        default: pick = word[7:0];
      endcase
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        holdQ  <= '0;
        shiftQ <= '0;
      end else begin
        if (stb.fetch) holdQ <= pick;
        if (stb.slotStart) shiftQ <= stb.loadByte ? holdQ : {shiftQ[6:0], 1'b0};
      end
    end

    assign curBits[l] = shiftQ[7];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              laneQ <= '0;
    else if (stb.markLong)  laneQ <= '0;
    else if (stb.markShort) laneQ <= laneQ & curBits;
    else if (stb.slotStart) laneQ <= laneMask;
  end

  assign laneOut = laneQ;

endmodule

// File: rtl/led_lane_tx.sv
module led_lane_tx
  import led_tx_pkg::*;
#(
  parameter int LANES    = 8,
  parameter int MAX_LEDS = 8,
  parameter int CLK_HZ   = 200_000_000,
  localparam int LANEW   = (LANES > 1) ? $clog2(LANES) : 1,
  localparam int LEDW    = (MAX_LEDS > 1) ? $clog2(MAX_LEDS) : 1,
  localparam int LENW    = $clog2(MAX_LEDS + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [LANEW-1:0] wrLane,
  input  logic [LEDW-1:0]  wrLed,
  input  logic [23:0]      wrColor,
  input  logic [2:0]       colorOrder,
  input  logic [LENW-1:0]  stripLen,
  input  logic [LANES-1:0] laneEn,
  input  logic             slowMode,
  input  logic             start,
  output logic             busy,
  output logic [LANES-1:0] laneOut
);

  localparam int SLOT_CYC  = CLK_HZ / 800_000;
  localparam int SHORT_CYC = CLK_HZ * 3 / 10_000_000;
  localparam int LONG_CYC  = CLK_HZ * 3 / 4_000_000;
  localparam int US_CYC    = CLK_HZ / 1_000_000;
  localparam int GAP_BASE  = 300 * US_CYC;
  localparam int GAP_BYTE  = 10 * US_CYC;

  txStrobe_t        stb;
  logic [LENW-1:0]  rdLed;
  logic [1:0]       rdSel;
  logic [LANES-1:0] laneMaskQ;

  led_tx_ctrl #(
    .LANES     (LANES),
    .MAX_LEDS  (MAX_LEDS),
    .LENW      (LENW),
    .SLOT_CYC  (SLOT_CYC),
    .SHORT_CYC (SHORT_CYC),
    .LONG_CYC  (LONG_CYC),
    .GAP_BASE  (GAP_BASE),
    .GAP_BYTE  (GAP_BYTE)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .stripLen  (stripLen),
    .slowMode  (slowMode),
    .laneEn    (laneEn),
    .stb       (stb),
    .rdLed     (rdLed),
    .rdSel     (rdSel),
    .laneMaskQ (laneMaskQ),
    .busy      (busy)
  );

  led_tx_datapath #(
    .LANES    (LANES),
    .MAX_LEDS (MAX_LEDS),
    .LENW     (LENW),
    .LANEW    (LANEW),
    .LEDW     (LEDW)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .wrEn       (wrEn),
    .wrLane     (wrLane),
    .wrLed      (wrLed),
    .wrColor    (wrColor),
    .colorOrder (colorOrder),
    .stb        (stb),
    .rdLed      (rdLed),
    .rdSel      (rdSel),
    .laneMask   (laneMaskQ),
    .laneOut    (laneOut)
  );

endmodule

// File: rtl/led_lane_tx_chk.sv
module led_lane_tx_chk #(
  parameter int LANES = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic             busy,
  input logic [LANES-1:0] laneOut,
  input logic [LANES-1:0] laneMaskQ
);

  AST_IDLE_LINES_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (laneOut == '0)); // R11

  AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy); // R9

  AST_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (start && busy) |=> $stable(laneMaskQ)); // R10

  AST_MASKED_LANE_LOW: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> ((laneOut & ~laneMaskQ) == '0)); // R8

  AST_COMMON_RISE: assert property (@(posedge clk) disable iff (!rstN)
    (($past(laneOut) == '0) && (laneOut != '0)) |-> (laneOut == laneMaskQ)); // R4

  AST_NO_LONE_RISE: assert property (@(posedge clk) disable iff (!rstN)
    ($past(laneOut) != '0) |-> ((laneOut & ~$past(laneOut)) == '0)); // R4

endmodule

bind led_lane_tx led_lane_tx_chk #(.LANES(LANES)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .start     (start),
  .busy      (busy),
  .laneOut   (laneOut),
  .laneMaskQ (laneMaskQ)
);

// File: tb/led_lane_tx_bench.sv
module led_lane_tx_bench;

  localparam int LANES    = 8;
  localparam int MAX_LEDS = 4;
  localparam int CLK_HZ   = 20_000_000;
  localparam int SLOT     = 25;
  localparam int SHORT    = 6;
  localparam int LONG     = 15;
  localparam int BASE     = 6000;
  localparam int PERBYTE  = 200;
  localparam int WATCHDOG = 190_000;

  // {order[26:24], slow[20], len[18:16], laneEn[15:8], seed[7:0]}
  localparam int NVEC = 8;
  localparam logic [31:0] VEC [NVEC] = '{
    32'h0002_FF01, 32'h0101_A502, 32'h0212_FF03, 32'h0304_0F04,
    32'h0403_F005, 32'h0511_8106, 32'h0601_FF07, 32'h0702_3C08
  };

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             wrEn = 1'b0;
  logic [2:0]       wrLane = '0;
  logic [1:0]       wrLed = '0;
  logic [23:0]      wrColor = '0;
  logic [2:0]       colorOrder = '0;
  logic [2:0]       stripLen = '0;
  logic [LANES-1:0] laneEn = '0;
  logic             slowMode = 1'b0;
  logic             start = 1'b0;
  logic             busy;
  logic [LANES-1:0] laneOut;

  always #2.5 clk = ~clk;

  led_lane_tx #(.LANES(LANES), .MAX_LEDS(MAX_LEDS), .CLK_HZ(CLK_HZ)) u_led_lane_tx (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrLane(wrLane), .wrLed(wrLed),
    .wrColor(wrColor), .colorOrder(colorOrder), .stripLen(stripLen),
    .laneEn(laneEn), .slowMode(slowMode), .start(start), .busy(busy),
    .laneOut(laneOut)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit timedOut = 1'b0;

  int expSlot = SLOT, expShort = SHORT, expLong = LONG;
  int capCnt [LANES];
  bit [95:0] capBits [LANES];
  int lastRise [LANES];
  bit highSeen [LANES];
  bit prevOut [LANES];
  int badW = 0, badP = 0;

  initial for (int l = 0; l < LANES; l++) begin
    capCnt[l] = 0; capBits[l] = '0; lastRise[l] = -1; highSeen[l] = 0; prevOut[l] = 0;
  end

  // waveform decoder, samples away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (cyc > WATCHDOG) timedOut = 1'b1;
    for (int l = 0; l < LANES; l++) begin
      if (laneOut[l]) highSeen[l] = 1'b1;
      if (laneOut[l] && !prevOut[l]) begin
        if (lastRise[l] >= 0 && (cyc - lastRise[l]) != expSlot) badP++;
        lastRise[l] = cyc;
      end else if (!laneOut[l] && prevOut[l]) begin
        int w;
        bit b;
        w = cyc - lastRise[l];
        b = 1'b0;
        if (w == expLong) b = 1'b1;
        else if (w != expShort) badW++;
        if (capCnt[l] < 96) capBits[l][capCnt[l]] = b;
        capCnt[l]++;
      end
      prevOut[l] = laneOut[l];
    end
  end

  function automatic logic [23:0] pixColor(int seed, int lane, int led);
    logic [7:0] r, g, b;
    r = 8'(seed * 29 + lane * 17 + led * 101);
    g = 8'(seed * 53 + lane * 7 + led * 13) ^ 8'h5A;
    b = 8'(seed * 3 + lane * 131 + led * 43) ^ 8'hC3;
    return {r, g, b};
  endfunction

  function automatic bit expBit(int seed, int lane, int order, int idx);
    logic [23:0] c, w;
    int led, k, bp;
    c = pixColor(seed, lane, idx / 24);
    case (order)
      1: w = {c[23:16], c[7:0], c[15:8]};
      2: w = {c[15:8], c[23:16], c[7:0]};
      3: w = {c[15:8], c[7:0], c[23:16]};
      4: w = {c[7:0], c[23:16], c[15:8]};
      5: w = {c[7:0], c[15:8], c[23:16]};
      default: w = c;
    endcase
    led = idx / 24;
    k = (idx % 24) / 8;
    bp = 23 - 8 * k - (idx % 8);
    if (led < 0) return 1'b0;
    return w[bp];
  endfunction

  task automatic check(bit ok, string req, int actual, int expected);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  task automatic clearMon(bit slow);
    @(posedge clk);
    for (int l = 0; l < LANES; l++) begin
      capCnt[l] = 0; capBits[l] = '0; lastRise[l] = -1; highSeen[l] = 0;
    end
    badW = 0; badP = 0;
    expSlot  = slow ? 2 * SLOT : SLOT;
    expShort = slow ? 2 * SHORT : SHORT;
    expLong  = slow ? 2 * LONG : LONG;
  endtask

  task automatic writePix(int lane, int led, logic [23:0] rgb, int order);
    @(negedge clk);
    wrEn = 1'b1; wrLane = 3'(lane); wrLed = 2'(led); wrColor = rgb; colorOrder = 3'(order);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  // one frame; pokeAt > 0 pulses start again that many busy cycles in
  task automatic runFrame(int order, bit slow, int len, logic [7:0] en, int seed, int pokeAt, string tag);
    int busyCnt, expBusy, mism;
    for (int l = 0; l < LANES; l++)
      for (int d = 0; d < len; d++) writePix(l, d, pixColor(seed, l, d), order);
    clearMon(slow);
    @(negedge clk);
    stripLen = 3'(len); laneEn = en; slowMode = slow; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    busyCnt = busy ? 1 : 0;
    while (busy && !timedOut) begin
      @(negedge clk);
      if (pokeAt > 0 && busyCnt == pokeAt) begin
        start = 1'b1; slowMode = ~slow; laneEn = ~en; stripLen = 3'd1;
      end else begin
        start = 1'b0;
      end
      if (busy) busyCnt++;
    end
    start = 1'b0;
    expBusy = BASE + PERBYTE * 3 * len * (slow ? 2 : 1);
    check(busyCnt == expBusy, slow ? "R9/R3 busy window" : "R9 busy window", busyCnt, expBusy);
    check(badW == 0, slow ? "R3 high widths" : "R2 high widths", badW, 0);
    check(badP == 0, "R4 slot spacing", badP, 0);
    for (int l = 0; l < LANES; l++) begin
      if (en[l]) begin
        check(capCnt[l] == len * 24, "R7 bit count", capCnt[l], len * 24);
        mism = 0;
        for (int i = 0; i < len * 24; i++)
          if (capBits[l][i] != expBit(seed, l, order, i)) mism++;
        check(mism == 0, (order == 0) ? "R5 bit stream" : "R6 byte order", mism, 0);
      end else begin
        check(!highSeen[l], "R8 disabled lane low", int'(highSeen[l]), 0);
      end
    end
    repeat (40) @(negedge clk);
    check(laneOut == '0 && !busy, "R11 idle low", int'(laneOut), 0);
    if (pokeAt > 0) begin
      int total;
      total = 0;
      for (int l = 0; l < LANES; l++) total += capCnt[l];
      check(total == len * 24 * $countones(en), "R10 no extra frame", total, len * 24 * $countones(en));
    end
    $display("frame %s done", tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(busy == 1'b0, "R1 busy after reset", int'(busy), 0);
    check(laneOut == '0, "R1 lanes after reset", int'(laneOut), 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check(busy == 1'b0 && laneOut == '0, "R1 idle after release", int'(busy), 0);

    for (int v = 0; v < NVEC && !timedOut; v++) begin
      logic [31:0] e;
      e = VEC[v];
      runFrame(int'(e[26:24]), e[20], int'(e[18:16]), e[15:8], int'(e[7:0]), 0, $sformatf("vec%0d", v));
    end

    // R10: start pulses during the send phase and during the latch gap
    if (!timedOut) runFrame(2, 1'b0, 2, 8'h5A, 9, 100, "poke-send");
    if (!timedOut) runFrame(0, 1'b0, 1, 8'hFF, 10, 3000, "poke-gap");
    // R7: zero length sends nothing, busy for base window only
    if (!timedOut) runFrame(0, 1'b0, 0, 8'hFF, 11, 0, "len0");

    if (timedOut) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, WATCHDOG);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule